// File: doc/BRIEF.md
# Mode-Selected Dual-Clock Shift Register

This block is a short chain of storage stages, four by default, driven by one fast system clock. Two slow strobe lines come into it as ordinary data signals, along with a mode input, a serial data bit and one parallel word. A synchronizer bank samples the strobes and the mode together. Each strobe then goes through its own two-state edge machine, which finds high-to-low transitions.

When mode is low, a falling edge on the shift strobe moves every stage one place toward the far end, and the serial bit enters the first stage. When mode is high, a falling edge on the load strobe copies the parallel word into the stages. The strobe that mode does not select has no effect. Neither does the data that belongs to the other operation.

A shift toward the first stage is made outside the block: each stage output is wired back to the parallel input of the stage before it, and new data goes into the last parallel bit. The last stage also drives a serial output, so several blocks can be chained into one longer register.

Top module: `shreg_dualclk`

The two edge machines each have states LINE_LOW and LINE_HIGH:
- LINE_LOW to LINE_HIGH when the synchronized line reads 1.
- LINE_HIGH to LINE_LOW when it reads 0. This transition raises the line's fall pulse for that cycle.

The stage operation is one of three:
- OP_HOLD
- OP_SHIFT, chosen when the synchronized mode is 0 and the shift line has a fall pulse.
- OP_LOAD, chosen when the synchronized mode is 1 and the load line has a fall pulse.

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, clears both edge machines to LINE_LOW and clears the synchronizers. A strobe held low through the release of reset causes no update.
- R2: With mode 0, a falling edge on `shift_clk_i` moves the stages: q_o[0] takes `ser_i`, and q_o[i] takes the old q_o[i-1].
- R3: With mode 0, `load_clk_i` and `par_i` have no effect on the stages.
- R4: With mode 1, a falling edge on `load_clk_i` sets q_o[i] to par_i[i] for every i. Bit 0 is the first stage.
- R5: With mode 1, `shift_clk_i` and `ser_i` have no effect on the stages.
- R6: Rising edges, and strobe lines held steady, leave all stages unchanged.
- R7: A strobe held low for many system cycles causes exactly one update.
- R8: A change of mode causes no update, whether both strobes are low or one of them is held low. This includes a switch from mode 1 to mode 0 while `shift_clk_i` is low.
- R9: With mode 1 and par_i wired as {new bit, q_o[3], q_o[2], q_o[1]} (par_i[3] is the new bit), each load pulse shifts the data toward q_o[0] and enters the new bit at q_o[3].
- R10: `ser_o` equals the last stage. Two chained blocks behave as one 8-stage register shifting from the first block into the second.
- R11: A falling strobe edge that arrives between system edges k-1 and k updates the stages at system edge k+2. The stages are still unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 selects shift, 1 selects parallel load |
| shift_clk_i | input | 1 | Shift strobe, acts on its falling edge |
| load_clk_i | input | 1 | Load strobe, acts on its falling edge |
| ser_i | input | 1 | Serial data entering stage 0 |
| par_i | input | N | Parallel load word, bit i for stage i |
| q_o | output | N | Stage outputs, bit 0 is the first stage |
| ser_o | output | 1 | Last stage, used for chaining |

## Verification
The most delicate case is a mode switch made while the newly selected strobe is already low. A design that picked the strobe before detecting edges would see a false falling edge there and shift or load without any pulse. The bench also holds a strobe low for a long time: a level-sensitive design would update on every cycle instead of once. It releases reset with a strobe held low, where stale edge history would cause a spurious update. Finally, it samples the cycle before the update and the cycle of the update, which catches a design that adds or drops a register on the way.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } shreg_op_e;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;

    localparam int SYNC_BITS = 3;
    localparam int IDX_SHIFT = 0;
    localparam int IDX_LOAD  = 1;
    localparam int IDX_MODE  = 2;

endpackage

// File: rtl/shreg_sync.sv
module shreg_sync #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[DEPTH-1];
endmodule

// File: rtl/shreg_fall_fsm.sv
module shreg_fall_fsm
    import shreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic fall_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LINE_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fall_o  = 1'b0;
        unique case (state_q)
            LINE_LOW: begin
                if (lvl_i) state_d = LINE_HIGH;
            end
            LINE_HIGH: begin
                if (!lvl_i) begin
                    state_d = LINE_LOW;
                    fall_o  = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/shreg_stages.sv
module shreg_stages
    import shreg_pkg::*;
#(
    parameter int N = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  shreg_op_e op_i,
    input  logic      ser_i,
    input  logic [N-1:0] par_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] link;

    for (genvar i = 0; i < N; i++) begin : g_link
        if (i == 0) begin : g_head
            assign link[i] = ser_i;
        end else begin : g_body
            assign link[i] = q_o[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[i] <= 1'b0;
            end else begin
                unique case (op_i)
                    OP_SHIFT: q_o[i] <= link[i];
                    OP_LOAD:  q_o[i] <= par_i[i];
                    default:  q_o[i] <= q_o[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/shreg_dualclk.sv
module shreg_dualclk
    import shreg_pkg::*;
#(
    parameter int N          = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_i,
    input  logic         shift_clk_i,
    input  logic         load_clk_i,
    input  logic         ser_i,
    input  logic [N-1:0] par_i,
    output logic [N-1:0] q_o,
    output logic         ser_o
);
    logic [SYNC_BITS-1:0] raw, synced;
    logic      mode_s, fall_r, fall_l;
    shreg_op_e op;

    always_comb begin
        raw            = '0;
        raw[IDX_SHIFT] = shift_clk_i;
        raw[IDX_LOAD]  = load_clk_i;
        raw[IDX_MODE]  = mode_i;
    end

    shreg_sync #(.DEPTH(SYNC_DEPTH), .WIDTH(SYNC_BITS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    assign mode_s = synced[IDX_MODE];

    shreg_fall_fsm u_edge_r (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (synced[IDX_SHIFT]),
        .fall_o (fall_r)
    );

    shreg_fall_fsm u_edge_l (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (synced[IDX_LOAD]),
        .fall_o (fall_l)
    );

    always_comb begin
        op = OP_HOLD;
        unique case (mode_s)
            1'b0: if (fall_r) op = OP_SHIFT;
            1'b1: if (fall_l) op = OP_LOAD;
        endcase
    end

    shreg_stages #(.N(N)) u_stages (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op),
        .ser_i (ser_i),
        .par_i (par_i),
        .q_o   (q_o)
    );

    assign ser_o = q_o[N-1];
endmodule

// File: rtl/shreg_dualclk_chk.sv
module shreg_dualclk_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_s,
    input logic         fall_r,
    input logic         fall_l,
    input logic         ser_i,
    input logic [N-1:0] par_i,
    input logic [N-1:0] q_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    assert_shift_move_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode_s && fall_r) |=> (q_o == {$past(q_o[N-2:0]), $past(ser_i)}));

    assert_load_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_s && fall_l) |=> (q_o == $past(par_i)));

    assert_no_edge_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!fall_r && !fall_l) |=> $stable(q_o));

    assert_one_pulse_r_R7: assert property (@(posedge clk) disable iff (rst)
        fall_r |=> !fall_r);

    assert_one_pulse_l_R7: assert property (@(posedge clk) disable iff (rst)
        fall_l |=> !fall_l);
endmodule

bind shreg_dualclk shreg_dualclk_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode_s (mode_s),
    .fall_r (fall_r),
    .fall_l (fall_l),
    .ser_i  (ser_i),
    .par_i  (par_i),
    .q_o    (q_o)
);

// File: tb/sim_shreg_dualclk.sv
module sim_shreg_dualclk;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, mode, ckr, ckl, ser, lsh_en, dnew;
    logic [3:0] par_drv, par_u0, q0, q1;
    logic       so0, so1;
    logic [7:0] exp8;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    assign par_u0 = lsh_en ? {dnew, q0[3:1]} : par_drv;

    shreg_dualclk u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .shift_clk_i(ckr), .load_clk_i(ckl),
        .ser_i(ser), .par_i(par_u0), .q_o(q0), .ser_o(so0)
    );

    shreg_dualclk uc1 (
        .clk(clk), .rst(rst), .mode_i(mode), .shift_clk_i(ckr), .load_clk_i(ckl),
        .ser_i(so0), .par_i(4'h0), .q_o(q1), .ser_o(so1)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, {q1, q0}, exp8);
        chk({tag, " ser_o"}, {7'd0, so1}, {7'd0, exp8[7]});
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode = m;
        settle(4);
    endtask

    task automatic pulse_r(input logic s, input int low_len);
        @(negedge clk);
        ser = s;
        ckr = 1'b0;
        if (!mode) exp8 = {exp8[6:0], s};
        settle(low_len);
        ckr = 1'b1;
        settle(4);
    endtask

    task automatic pulse_l(input logic [3:0] p, input int low_len);
        @(negedge clk);
        par_drv = p;
        ckl = 1'b0;
        if (mode) exp8 = {4'h0, (lsh_en ? {dnew, exp8[3:1]} : p)};
        settle(low_len);
        ckl = 1'b1;
        settle(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode = 1'b0; ckr = 1'b1; ckl = 1'b1; ser = 1'b0;
        lsh_en = 1'b0; dnew = 1'b0; par_drv = 4'h0; exp8 = 8'h00;
        settle(4);
        check_all("R1 reset state");
        rst = 1'b0;
        settle(4);

        // R4: every parallel word
        set_mode(1'b1);
        for (int p = 0; p < 16; p++) begin
            pulse_l(p[3:0], 5);
            check_all("R4 load sweep");
        end

        // R1: reset with shift strobe held low
        pulse_l(4'hF, 5);
        @(negedge clk);
        rst = 1'b1; mode = 1'b0; ckr = 1'b0;
        settle(3);
        exp8 = 8'h00;
        check_all("R1 reset clears");
        rst = 1'b0;
        settle(8);
        check_all("R1 no edge after reset");
        ckr = 1'b1;
        settle(4);
        check_all("R6 rising edge ignored");

        // R2 / R10: 16 serial bits through the chain
        for (int i = 0; i < 16; i++) begin
            logic [15:0] pat;
            pat = 16'hB4E1;
            pulse_r(pat[i], 5);
            check_all("R2 R10 chain shift");
        end

        // R11: update lands on the third system edge
        @(negedge clk);
        ser = ~exp8[0];
        ckr = 1'b0;
        settle(2);
        check_all("R11 before update");
        exp8 = {exp8[6:0], ser};
        settle(1);
        check_all("R11 at update");
        settle(3);
        ckr = 1'b1;
        settle(4);

        // R7: long low period yields one shift
        pulse_r(1'b1, 40);
        check_all("R7 one shift per pulse");

        // R3: load strobe and parallel word ignored in mode 0
        for (int p = 0; p < 4; p++) begin
            pulse_l(4'hA ^ p[3:0], 6);
            check_all("R3 load ignored");
        end

        // R8: mode change with both strobes low
        @(negedge clk); ckl = 1'b0;
        settle(4);
        pulse_r(1'b0, 0);
        @(negedge clk); ckr = 1'b0;
        settle(4);
        check_all("R8 pre mode change");
        set_mode(1'b1);
        check_all("R8 mode change both low");
        set_mode(1'b0);
        check_all("R8 mode change back both low");
        @(negedge clk); ckr = 1'b1; ckl = 1'b1;
        settle(4);
        check_all("R8 R6 release both");

        // R8: mode 1 -> 0 while shift strobe low, load strobe high
        set_mode(1'b1);
        @(negedge clk); ckr = 1'b0;
        settle(5);
        check_all("R5 shift strobe ignored");
        set_mode(1'b0);
        check_all("R8 switch onto low shift strobe");
        set_mode(1'b1);
        check_all("R8 switch away");
        @(negedge clk); ckr = 1'b1;
        settle(4);

        // R5: shift strobe and serial input ignored in mode 1
        pulse_r(1'b1, 5);
        check_all("R5 shift ignored");

        // R9: left shift by external wiring
        pulse_l(4'h6, 5);
        check_all("R9 seed");
        lsh_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            dnew = i[0] ^ i[1];
            pulse_l(4'h0, 5);
            check_all("R9 left shift");
        end
        lsh_en = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule